// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block watches the data phases that a two-port bridge receives on its primary and on its secondary bus and checks each against the parity bit that arrives one clock later. Parity is even and covers the 32 address/data lines together with the 4 byte-enable lines. When the check fails, the block takes four actions. It pulls that bus's active-low parity-error output low, provided that bus's response enable is set. It sets a sticky detected bit. It raises a bad-parity flag towards the opposite bus, so the fault travels with the forwarded data. For a delayed write, it tells the queue whether the write status may be returned or the request must stay queued.

A second path handles errors that the target bus reports back for a transfer whose parity looked clean on the initiator side. The initiator-side error output is pulsed for that transfer, again only if that side's enable is set. The transaction always completes normally. The block only reports; it never aborts or corrects data. The enable bits, detected bits and clear strobes are plain ports. The register decode lives elsewhere.

Top module: `bpe_reporter`

## Requirements
- R1: While reset is applied and after it is released, both parity-error outputs are high and every status, forward and write-status output is 0.
- R2: A received data phase (`*_dphase` high in cycle k) has a parity error when the `*_par` value in cycle k+1 differs from the XOR of the 32 `*_ad` bits and 4 `*_be` bits sampled in cycle k. An all-ones pattern (36 ones) expects parity 0.
- R3: With `*_resp_en` high, an erroneous phase in cycle k drives that side's `*_perr_n` low during cycle k+2 for exactly one cycle. Errors in consecutive cycles give consecutive low cycles.
- R4: With `*_resp_en` low, a parity error leaves `*_perr_n` high, but the side's `*_det` bit is still set.
- R5: `*_det` stays set until a cycle with `*_det_clr` high. If the clear lands in the same cycle as a new error's parity check (cycle k+1), the bit stays set.
- R6: A parity error on the primary side pulses `p2s_bad` in cycle k+2, and one on the secondary side pulses `s2p_bad`. This happens regardless of the response enable.
- R7: For a phase marked `*_dlywr`, cycle k+2 shows a one-cycle pulse on `*_stat_ret` if parity matched, or on `*_stat_keep` if it did not. Never both.
- R8: A phase with `*_retperr` high drives `*_perr_n` low in cycle k+2 when `*_resp_en` is high, even with good parity. It neither sets `*_det` nor pulses the forward flag.
- R9: The two sides are independent. An error on one side changes no output of the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| p_ad | input | 32 | Primary address/data lines |
| p_be | input | 4 | Primary byte enables |
| p_dphase | input | 1 | Primary data phase received this cycle |
| p_par | input | 1 | Primary parity bit, valid the cycle after the data phase |
| p_dlywr | input | 1 | Primary phase is a delayed-write completion attempt |
| p_retperr | input | 1 | Target bus reported a parity error for this primary transfer |
| p_resp_en | input | 1 | Primary parity-error response enable |
| p_det_clr | input | 1 | Write-one-to-clear strobe for `p_det` |
| p_perr_n | output | 1 | Primary parity-error output, active low |
| p_det | output | 1 | Primary parity-error-detected sticky bit |
| p2s_bad | output | 1 | Bad parity to present on the secondary bus |
| p_stat_ret | output | 1 | Primary delayed write: status may be returned |
| p_stat_keep | output | 1 | Primary delayed write: keep request queued |
| s_ad | input | 32 | Secondary address/data lines |
| s_be | input | 4 | Secondary byte enables |
| s_dphase | input | 1 | Secondary data phase received this cycle |
| s_par | input | 1 | Secondary parity bit, valid the cycle after the data phase |
| s_dlywr | input | 1 | Secondary phase is a delayed-write completion attempt |
| s_retperr | input | 1 | Target bus reported a parity error for this secondary transfer |
| s_resp_en | input | 1 | Secondary parity-error response enable |
| s_det_clr | input | 1 | Write-one-to-clear strobe for `s_det` |
| s_perr_n | output | 1 | Secondary parity-error output, active low |
| s_det | output | 1 | Secondary parity-error-detected sticky bit |
| s2p_bad | output | 1 | Bad parity to present on the primary bus |
| s_stat_ret | output | 1 | Secondary delayed write: status may be returned |
| s_stat_keep | output | 1 | Secondary delayed write: keep request queued |

## Verification
Every per-phase result falls in the second cycle after the cycle in which the data phase is driven. This covers the error output, the forward flag and the two delayed-write status pulses. The detected bit follows in that same cycle and then holds. The driver stamps each expected item with the current cycle count plus two. The monitor samples on the falling edge and compares an item only when the running count equals that stamp, so idle cycles are checked as well. Detected-bit checks are made after idle cycles, once nothing is still in flight. The clear-versus-new-error case places the clear in the cycle that carries the parity bit.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  parameter int BPE_AD_W = 32;

  // One received data phase waiting for its parity bit
  typedef struct packed {
    logic v;     // a phase was received
    logic par;   // expected even parity
    logic dly;   // delayed-write completion attempt
    logic ret;   // target bus reported an error for it
  } bpe_pend_t;
endpackage

// File: rtl/bpe_par_tree.sv
module bpe_par_tree #(
  parameter int W = 36
) (
  input  logic [W-1:0] bits,
  output logic         par_even
);
  localparam int HALF = W / 2;

  generate
    if (W == 1) begin : g_leaf
      assign par_even = bits[0];
    end else begin : g_split
      logic lo, hi;
      bpe_par_tree #(.W(HALF))     u_lo (.bits(bits[HALF-1:0]), .par_even(lo));
      bpe_par_tree #(.W(W - HALF)) u_hi (.bits(bits[W-1:HALF]), .par_even(hi));
      assign par_even = lo ^ hi;
    end
  endgenerate
endmodule

// File: rtl/bpe_side.sv
module bpe_side
  import bpe_pkg::*;
#(
  parameter int AD_W = BPE_AD_W,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] be,
  input  logic            dphase,
  input  logic            par,
  input  logic            dlywr,
  input  logic            retperr,
  input  logic            resp_en,
  input  logic            det_clr,
  output logic            perr_n,
  output logic            det,
  output logic            fwd_bad,
  output logic            stat_ret,
  output logic            stat_keep
);
  logic      calc_par;
  bpe_pend_t pend_q, pend_d;
  logic      mis;
  logic      perr_q, perr_d;
  logic      det_q, det_d, det_upd;
  logic      fwd_q, fwd_d;
  logic      ret_q, ret_d;
  logic      keep_q, keep_d;

  bpe_par_tree #(.W(AD_W + BE_W)) u_tree (
    .bits    ({ad, be}),
    .par_even(calc_par)
  );

  // next state
  always_comb begin
    pend_d.v   = dphase;
    pend_d.par = calc_par;
    pend_d.dly = dphase & dlywr;
    pend_d.ret = dphase & retperr;

    mis     = pend_q.v & (par ^ pend_q.par);
    perr_d  = resp_en & (mis | pend_q.ret);
    det_d   = mis | (det_q & ~det_clr);
    det_upd = mis | det_clr;
    fwd_d   = mis;
    ret_d   = pend_q.dly & ~mis;
    keep_d  = pend_q.dly & mis;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      perr_q <= 1'b0;
      det_q  <= 1'b0;
      fwd_q  <= 1'b0;
      ret_q  <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      perr_q <= perr_d;
      if (det_upd) det_q <= det_d;
      fwd_q  <= fwd_d;
      ret_q  <= ret_d;
      keep_q <= keep_d;
    end
  end

  assign perr_n    = ~perr_q;
  assign det       = det_q;
  assign fwd_bad   = fwd_q;
  assign stat_ret  = ret_q;
  assign stat_keep = keep_q;

  assert_perr_two_after_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(dphase, 2));
  assert_perr_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(resp_en));
  assert_det_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(det) && !$past(det_clr)) |-> det);
  assert_fwd_with_det_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_bad |-> det);
  assert_status_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_ret && stat_keep));
  assert_status_from_dlywr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ret || stat_keep) |-> $past(dlywr, 2));
endmodule

// File: rtl/bpe_reporter.sv
module bpe_reporter
  import bpe_pkg::*;
#(
  parameter int AD_W = BPE_AD_W,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] p_ad,
  input  logic [BE_W-1:0] p_be,
  input  logic            p_dphase,
  input  logic            p_par,
  input  logic            p_dlywr,
  input  logic            p_retperr,
  input  logic            p_resp_en,
  input  logic            p_det_clr,
  output logic            p_perr_n,
  output logic            p_det,
  output logic            p2s_bad,
  output logic            p_stat_ret,
  output logic            p_stat_keep,
  input  logic [AD_W-1:0] s_ad,
  input  logic [BE_W-1:0] s_be,
  input  logic            s_dphase,
  input  logic            s_par,
  input  logic            s_dlywr,
  input  logic            s_retperr,
  input  logic            s_resp_en,
  input  logic            s_det_clr,
  output logic            s_perr_n,
  output logic            s_det,
  output logic            s2p_bad,
  output logic            s_stat_ret,
  output logic            s_stat_keep
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0][AD_W-1:0] ad_a;
  logic [NSIDE-1:0][BE_W-1:0] be_a;
  logic [NSIDE-1:0] dph_a, par_a, dly_a, rt_a, en_a, clr_a;
  logic [NSIDE-1:0] perr_a, det_a, fwd_a, ret_a, keep_a;

  assign ad_a  = {s_ad, p_ad};
  assign be_a  = {s_be, p_be};
  assign dph_a = {s_dphase, p_dphase};
  assign par_a = {s_par, p_par};
  assign dly_a = {s_dlywr, p_dlywr};
  assign rt_a  = {s_retperr, p_retperr};
  assign en_a  = {s_resp_en, p_resp_en};
  assign clr_a = {s_det_clr, p_det_clr};

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    bpe_side #(.AD_W(AD_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .ad       (ad_a[i]),
      .be       (be_a[i]),
      .dphase   (dph_a[i]),
      .par      (par_a[i]),
      .dlywr    (dly_a[i]),
      .retperr  (rt_a[i]),
      .resp_en  (en_a[i]),
      .det_clr  (clr_a[i]),
      .perr_n   (perr_a[i]),
      .det      (det_a[i]),
      .fwd_bad  (fwd_a[i]),
      .stat_ret (ret_a[i]),
      .stat_keep(keep_a[i])
    );
  end

  assign p_perr_n    = perr_a[0];
  assign p_det       = det_a[0];
  assign p2s_bad     = fwd_a[0];
  assign p_stat_ret  = ret_a[0];
  assign p_stat_keep = keep_a[0];
  assign s_perr_n    = perr_a[1];
  assign s_det       = det_a[1];
  assign s2p_bad     = fwd_a[1];
  assign s_stat_ret  = ret_a[1];
  assign s_stat_keep = keep_a[1];
endmodule

// File: tb/bpe_reporter_tb_top.sv
module bpe_reporter_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] ad [2];
  logic [3:0]  be [2];
  logic dph[2], par[2], dly[2], rt[2], en[2], clr[2];
  logic perr_n[2], det[2], fwd[2], sret[2], skeep[2];

  bpe_reporter dut_i (
    .clk(clk), .rst_n(rst_n),
    .p_ad(ad[0]), .p_be(be[0]), .p_dphase(dph[0]), .p_par(par[0]),
    .p_dlywr(dly[0]), .p_retperr(rt[0]), .p_resp_en(en[0]), .p_det_clr(clr[0]),
    .p_perr_n(perr_n[0]), .p_det(det[0]), .p2s_bad(fwd[0]),
    .p_stat_ret(sret[0]), .p_stat_keep(skeep[0]),
    .s_ad(ad[1]), .s_be(be[1]), .s_dphase(dph[1]), .s_par(par[1]),
    .s_dlywr(dly[1]), .s_retperr(rt[1]), .s_resp_en(en[1]), .s_det_clr(clr[1]),
    .s_perr_n(perr_n[1]), .s_det(det[1]), .s2p_bad(fwd[1]),
    .s_stat_ret(sret[1]), .s_stat_keep(skeep[1])
  );

  typedef struct {
    int       due;
    int       side;
    logic [3:0] exp;   // {perr_n, fwd, ret, keep}
    string    tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  // next-step stimulus per side
  logic n_ph[2], n_bad[2], n_dly[2], n_rt[2], n_clr[2], n_fix[2];
  logic [35:0] n_pat[2];
  logic pend_par[2];

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_next();
    for (int s = 0; s < 2; s++) begin
      n_ph[s] = 0; n_bad[s] = 0; n_dly[s] = 0; n_rt[s] = 0;
      n_clr[s] = 0; n_fix[s] = 0; n_pat[s] = '0;
    end
  endtask

  // driver: one call = one clock cycle of stimulus, pushes expectations
  task automatic step();
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      item_t it;
      logic err;
      par[s] = pend_par[s];
      if (n_fix[s]) begin
        ad[s] = n_pat[s][35:4];
        be[s] = n_pat[s][3:0];
      end else begin
        ad[s] = $urandom;
        be[s] = 4'($urandom);
      end
      dph[s] = n_ph[s];
      dly[s] = n_dly[s];
      rt[s]  = n_rt[s];
      clr[s] = n_clr[s];
      pend_par[s] = (^{ad[s], be[s]}) ^ n_bad[s];
      err = n_ph[s] & n_bad[s];
      it.due  = cyc + 2;
      it.side = s;
      it.exp  = {~(en[s] & (err | (n_ph[s] & n_rt[s]))), err,
                 n_ph[s] & n_dly[s] & ~n_bad[s], n_ph[s] & n_dly[s] & n_bad[s]};
      it.tag  = cur_tag;
      q.push_back(it);
    end
    clear_next();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // monitor: compares scoreboard items in the cycle they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [3:0] act;
      it = q.pop_front();
      if (it.due == cyc) begin
        act = {perr_n[it.side], fwd[it.side], sret[it.side], skeep[it.side]};
        check(act === it.exp, it.tag,
              $sformatf("side%0d {perr_n,fwd,ret,keep} cycle %0d", it.side, cyc),
              int'(act), int'(it.exp));
      end
    end
  end

  task automatic check_det(input int s, input logic exp, input string tag);
    @(negedge clk);
    check(det[s] === exp, tag, $sformatf("side%0d det", s), int'(det[s]), int'(exp));
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 0;
    for (int s = 0; s < 2; s++) begin
      ad[s] = '0; be[s] = '0; dph[s] = 0; par[s] = 0; dly[s] = 0;
      rt[s] = 0; en[s] = 1; clr[s] = 0; pend_par[s] = 0;
    end
    clear_next();
    cur_tag = "R1";
    idle(4);
    check_det(0, 0, "R1");
    check_det(1, 0, "R1");
    @(negedge clk) rst_n = 1;
    idle(3);
    check_det(0, 0, "R1");

    // R2 / R3: good and bad phases with varied data
    cur_tag = "R2";
    n_ph[0] = 1; step();
    n_ph[0] = 1; n_bad[0] = 1; step();
    n_ph[0] = 1; n_fix[0] = 1; n_pat[0] = '1; step();
    n_ph[0] = 1; n_fix[0] = 1; n_pat[0] = 36'h000000010; n_bad[0] = 1; step();
    n_ph[0] = 1; n_fix[0] = 1; n_pat[0] = 36'h000000001; step();
    idle(2);
    cur_tag = "R3";
    n_ph[0] = 1; n_bad[0] = 1; step();
    n_ph[0] = 1; n_bad[0] = 1; step();
    n_ph[0] = 1; n_bad[0] = 1; step();
    n_ph[0] = 1; step();
    idle(3);

    // R5: clear then set-wins
    cur_tag = "R5";
    n_clr[0] = 1; step();
    idle(2);
    check_det(0, 0, "R5");
    n_ph[0] = 1; n_bad[0] = 1; step();
    n_clr[0] = 1; step();
    idle(2);
    check_det(0, 1, "R5");
    n_clr[0] = 1; step();
    idle(2);
    check_det(0, 0, "R5");

    // R4: enable off, detection still recorded
    cur_tag = "R4";
    en[0] = 0;
    idle(2);
    n_ph[0] = 1; n_bad[0] = 1; step();
    idle(3);
    check_det(0, 1, "R4");
    en[0] = 1;
    n_clr[0] = 1; step();
    idle(3);

    // R6: forward with enable off on secondary
    cur_tag = "R6";
    en[1] = 0;
    idle(2);
    n_ph[1] = 1; n_bad[1] = 1; step();
    idle(3);
    en[1] = 1;
    idle(2);
    n_ph[1] = 1; n_bad[1] = 1; step();
    idle(3);

    // R7: delayed-write status
    cur_tag = "R7";
    n_ph[1] = 1; n_dly[1] = 1; step();
    n_ph[1] = 1; n_dly[1] = 1; n_bad[1] = 1; step();
    n_ph[1] = 1; n_dly[1] = 1; step();
    idle(3);
    n_clr[1] = 1; step();
    idle(3);

    // R8: error passed back from the target bus
    cur_tag = "R8";
    n_ph[0] = 1; n_rt[0] = 1; step();
    idle(3);
    check_det(0, 0, "R8");
    en[0] = 0;
    idle(2);
    n_ph[0] = 1; n_rt[0] = 1; step();
    idle(3);
    en[0] = 1;
    idle(2);

    // R9: sides independent
    cur_tag = "R9";
    n_ph[0] = 1; n_bad[0] = 1; n_ph[1] = 1; step();
    n_ph[1] = 1; n_bad[1] = 1; n_ph[0] = 1; n_dly[0] = 1; step();
    idle(3);
    check_det(0, 1, "R9");
    n_clr[1] = 1; step();
    n_ph[0] = 1; n_bad[0] = 1; step();
    idle(3);
    check_det(1, 0, "R9");

    idle(4);
    report();
  end
endmodule